// File: doc/BRIEF.md
# Four-Function Add/Subtract Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for a datapath of configurable width. It takes two unsigned operand words and a two-bit function code. It returns one result word at the operand width and a separate carry flag. One adder handles both addition and subtraction, and it is built as a chain of one-bit full adders in which each carry feeds the next stage. For subtraction, the second operand goes through a word-wide 2-to-1 selector that picks its bitwise inverse. The same control bit drives the carry into the lowest stage, so the adder computes the two's-complement difference.

The low function bit picks between the two arithmetic operations and, separately, between the two bitwise operations. The high function bit then picks between the arithmetic pair and the bitwise pair. There is no clock and no reset. The outputs follow the present inputs only.

A parameter picks how each one-bit stage is built: either as direct sum and majority equations, or as two half adders joined by an OR gate. Both forms are required to be equivalent.

Top module: `quad_alu`

## Requirements
- R1: With function code 2'b00, `result` equals `op_a + op_b` modulo 2^WIDTH.
- R2: With function code 2'b00, `carry_out` equals bit WIDTH of the unsigned (WIDTH+1)-bit sum of the operands.
- R3: With function code 2'b01, `result` equals `op_a - op_b` modulo 2^WIDTH, which is `op_a + ~op_b + 1` in two's complement.
- R4: With function code 2'b01, `carry_out` is the final adder carry of `op_a + ~op_b + 1`. It is 1 exactly when `op_a >= op_b` as unsigned numbers.
- R5: With function code 2'b10, `result` is the bitwise AND of the operands and `carry_out` is 0.
- R6: With function code 2'b11, `result` is the bitwise OR of the operands and `carry_out` is 0.
- R7: Outputs depend only on the current inputs. Applying the same inputs again after different inputs gives the same outputs, and all-zero inputs give a zero result and a zero carry.
- R8: R1 to R6 hold for every operand combination at WIDTH = 4, as well as at the default WIDTH of 32.
- R9: The half-adder stage variant (`HALF_ADDER_STAGES = 1`) gives the same outputs as the equation variant for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand (minuend for subtraction) |
| op_b | input | WIDTH | Second operand (subtrahend for subtraction) |
| func_sel | input | 2 | Function code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH | Result word at the operand width |
| carry_out | output | 1 | Final adder carry for add/subtract; 0 for bitwise functions |

## Verification
The checker's immediate assertions assume that the operand and function inputs hold known two-state values whenever the outputs are compared. They also assume that each input set is held steady long enough for the ripple chain to settle. The bench meets these assumptions by driving every input from declared zero values. It changes the inputs only just after the rising edge of its own timing clock and samples half a period later, so each comparison sees one fully applied set of inputs. At width 4 the stimulus covers every operand pair and every function code. At width 32 it uses carry-chain corner words and pseudo-random operands.

// File: rtl/quad_alu_pkg.sv
package quad_alu_pkg;

   typedef enum logic [1:0] {
      FN_ADD = 2'b00,
      FN_SUB = 2'b01,
      FN_AND = 2'b10,
      FN_OR  = 2'b11
   } alu_fn_e;

   localparam int unsigned FN_BITS = 2;

endpackage

// File: rtl/quad_alu_mux2.sv
module quad_alu_mux2 #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] in0,
   input  logic [WIDTH-1:0] in1,
   input  logic             pick,
   output logic [WIDTH-1:0] out
);
   if (WIDTH < 1) begin : g_bad_width
      $error("quad_alu_mux2: WIDTH must be at least 1");
   end

   always_comb begin
      out = pick ? in1 : in0;
   end
endmodule

// File: rtl/quad_alu_fa.sv
module quad_alu_fa #(
   parameter bit HALF_ADDER_STAGES = 1'b0
) (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   if (HALF_ADDER_STAGES) begin : g_halves
      logic s_lo, c_lo, c_hi;
      // first half adder: the two operand bits
      assign s_lo = a ^ b;
      assign c_lo = a & b;
      // second half adder: partial sum with the incoming carry
      assign s    = s_lo ^ ci;
      assign c_hi = s_lo & ci;
      assign co   = c_lo | c_hi;
   end else begin : g_direct
      // parity for the sum, majority for the carry
      assign s  = a ^ b ^ ci;
      assign co = (a & b) | (b & ci) | (ci & a);
   end
endmodule

// File: rtl/quad_alu_ripple.sv
module quad_alu_ripple #(
   parameter int unsigned WIDTH             = 32,
   parameter bit          HALF_ADDER_STAGES = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int unsigned CHAIN = WIDTH + 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("quad_alu_ripple: WIDTH must be at least 1");
   end

   logic [CHAIN-1:0] carry;

   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      quad_alu_fa #(
         .HALF_ADDER_STAGES(HALF_ADDER_STAGES)
      ) u_fa (
         .a (a[i]),
         .b (b[i]),
         .ci(carry[i]),
         .s (sum[i]),
         .co(carry[i+1])
      );
   end

   assign cout = carry[CHAIN-1];
endmodule

// File: rtl/quad_alu_bitwise.sv
module quad_alu_bitwise #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             pick_or,
   output logic [WIDTH-1:0] out
);
   logic [WIDTH-1:0] conj, disj;

   assign conj = a & b;
   assign disj = a | b;

   quad_alu_mux2 #(.WIDTH(WIDTH)) u_sel (
      .in0 (conj),
      .in1 (disj),
      .pick(pick_or),
      .out (out)
   );
endmodule

// File: rtl/quad_alu.sv
module quad_alu #(
   parameter int unsigned WIDTH             = 32,
   parameter bit          HALF_ADDER_STAGES = 1'b0
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [1:0]       func_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   import quad_alu_pkg::*;

   localparam int unsigned SEL_W = FN_BITS;

   if (WIDTH < 1) begin : g_bad_width
      $error("quad_alu: WIDTH must be at least 1");
   end
   if (SEL_W != 2) begin : g_bad_sel
      $error("quad_alu: function code must be two bits");
   end

   logic             low_bit;   // subtract within arithmetic, OR within bitwise
   logic             high_bit;  // bitwise pair when set
   logic [WIDTH-1:0] b_inv;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] arith_out;
   logic [WIDTH-1:0] logic_out;
   logic             arith_carry;

   assign low_bit  = func_sel[0];
   assign high_bit = func_sel[1];
   assign b_inv    = ~op_b;

   // operand conditioning: same control feeds the chain carry-in
   quad_alu_mux2 #(.WIDTH(WIDTH)) u_b_sel (
      .in0 (op_b),
      .in1 (b_inv),
      .pick(low_bit),
      .out (b_eff)
   );

   quad_alu_ripple #(
      .WIDTH            (WIDTH),
      .HALF_ADDER_STAGES(HALF_ADDER_STAGES)
   ) u_adder (
      .a   (op_a),
      .b   (b_eff),
      .cin (low_bit),
      .sum (arith_out),
      .cout(arith_carry)
   );

   quad_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a      (op_a),
      .b      (op_b),
      .pick_or(low_bit),
      .out    (logic_out)
   );

   quad_alu_mux2 #(.WIDTH(WIDTH)) u_out_sel (
      .in0 (arith_out),
      .in1 (logic_out),
      .pick(high_bit),
      .out (result)
   );

   assign carry_out = arith_carry & ~high_bit;
endmodule

// File: rtl/quad_alu_chk.sv
module quad_alu_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [1:0]       func_sel,
   input logic [WIDTH-1:0] result,
   input logic             carry_out
);
   import quad_alu_pkg::*;

   logic [WIDTH:0] wide_sum;

   always_comb begin
      wide_sum = {1'b0, op_a} + {1'b0, op_b};
      if (func_sel == FN_ADD) begin
         assert_add_result_R1: assert (result == wide_sum[WIDTH-1:0])
            else $error("add result mismatch");
         assert_add_carry_R2: assert (carry_out == wide_sum[WIDTH])
            else $error("add carry mismatch");
      end
      if (func_sel == FN_SUB) begin
         assert_sub_result_R3: assert (result == WIDTH'(op_a - op_b))
            else $error("subtract result mismatch");
         assert_sub_carry_R4: assert (carry_out == (op_a >= op_b))
            else $error("subtract carry mismatch");
      end
      if (func_sel == FN_AND) begin
         assert_and_R5: assert (result == (op_a & op_b) && !carry_out)
            else $error("AND mismatch");
      end
      if (func_sel == FN_OR) begin
         assert_or_R6: assert (result == (op_a | op_b) && !carry_out)
            else $error("OR mismatch");
      end
   end
endmodule

bind quad_alu quad_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a     (op_a),
   .op_b     (op_b),
   .func_sel (func_sel),
   .result   (result),
   .carry_out(carry_out)
);

// File: tb/quad_alu_bench.sv
`timescale 1ns/1ps
module quad_alu_bench;
   import quad_alu_pkg::*;

   typedef struct {
      logic [31:0] res;
      logic        cy;
      string       tag_r;
      string       tag_c;
   } exp_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // wide instance
   logic [31:0] a32 = '0, b32 = '0;
   logic [1:0]  f32 = 2'b00;
   logic [31:0] r32;
   logic        c32;

   quad_alu #(.WIDTH(32)) u_quad_alu (
      .op_a(a32), .op_b(b32), .func_sel(f32), .result(r32), .carry_out(c32)
   );

   // narrow instances: equation stages and half-adder stages
   logic [3:0] a4 = '0, b4 = '0;
   logic [1:0] f4 = 2'b00;
   logic [3:0] r4, r4h;
   logic       c4, c4h;

   quad_alu #(.WIDTH(4)) u_quad_alu_w4 (
      .op_a(a4), .op_b(b4), .func_sel(f4), .result(r4), .carry_out(c4)
   );
   quad_alu #(.WIDTH(4), .HALF_ADDER_STAGES(1'b1)) u_quad_alu_w4h (
      .op_a(a4), .op_b(b4), .func_sel(f4), .result(r4h), .carry_out(c4h)
   );

   exp_t q32[$];
   exp_t q4[$];

   function automatic exp_t model32(logic [31:0] a, logic [31:0] b, logic [1:0] f);
      exp_t e;
      logic [32:0] s;
      s = {1'b0, a} + {1'b0, b};
      case (f)
         2'b00: begin e.res = s[31:0]; e.cy = s[32];  e.tag_r = "R1"; e.tag_c = "R2"; end
         2'b01: begin e.res = a - b;   e.cy = (a >= b); e.tag_r = "R3"; e.tag_c = "R4"; end
         2'b10: begin e.res = a & b;   e.cy = 1'b0;    e.tag_r = "R5"; e.tag_c = "R5"; end
         default: begin e.res = a | b; e.cy = 1'b0;    e.tag_r = "R6"; e.tag_c = "R6"; end
      endcase
      return e;
   endfunction

   function automatic exp_t model4(logic [3:0] a, logic [3:0] b, logic [1:0] f);
      exp_t e;
      logic [4:0] s;
      logic [3:0] d;
      s = {1'b0, a} + {1'b0, b};
      d = a - b;
      e.res = '0;
      case (f)
         2'b00: begin e.res[3:0] = s[3:0]; e.cy = s[4];    e.tag_r = "R8 R1"; e.tag_c = "R8 R2"; end
         2'b01: begin e.res[3:0] = d;      e.cy = (a >= b); e.tag_r = "R8 R3"; e.tag_c = "R8 R4"; end
         2'b10: begin e.res[3:0] = a & b;  e.cy = 1'b0;    e.tag_r = "R8 R5"; e.tag_c = "R8 R5"; end
         default: begin e.res[3:0] = a | b; e.cy = 1'b0;   e.tag_r = "R8 R6"; e.tag_c = "R8 R6"; end
      endcase
      return e;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: apply just after the rising edge, push the expectation
   task automatic drive32(logic [31:0] a, logic [31:0] b, logic [1:0] f, string tg);
      exp_t e;
      @(posedge clk);
      #1;
      a32 = a; b32 = b; f32 = f;
      e = model32(a, b, f);
      if (tg != "") begin e.tag_r = tg; e.tag_c = tg; end
      q32.push_back(e);
   endtask

   task automatic drive4(logic [3:0] a, logic [3:0] b, logic [1:0] f);
      @(posedge clk);
      #1;
      a4 = a; b4 = b; f4 = f;
      q4.push_back(model4(a, b, f));
   endtask

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      if (q32.size() > 0) begin
         exp_t e;
         e = q32.pop_front();
         check(e.tag_r, r32, e.res);
         check(e.tag_c, {31'b0, c32}, {31'b0, e.cy});
      end
      if (q4.size() > 0) begin
         exp_t e;
         e = q4.pop_front();
         check(e.tag_r, {28'b0, r4}, e.res);
         check(e.tag_c, {31'b0, c4}, {31'b0, e.cy});
         check("R9 result", {28'b0, r4h}, {28'b0, r4});
         check("R9 carry", {31'b0, c4h}, {31'b0, c4});
      end
   end

   initial begin
      logic [31:0] ra, rb;
      // R7: all-zero inputs give zero outputs
      drive32(32'h0, 32'h0, 2'b00, "R7");
      // R1 R2: carry chain corners
      drive32(32'hFFFF_FFFF, 32'h0000_0001, FN_ADD, "");
      drive32(32'h8000_0000, 32'h8000_0000, FN_ADD, "");
      drive32(32'h7FFF_FFFF, 32'h0000_0001, FN_ADD, "");
      drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, FN_ADD, "");
      // R3 R4: borrow corners
      drive32(32'h0000_0000, 32'h0000_0001, FN_SUB, "");
      drive32(32'h1234_5678, 32'h1234_5678, FN_SUB, "");
      drive32(32'h0000_0000, 32'h0000_0000, FN_SUB, "");
      drive32(32'h8000_0000, 32'hFFFF_FFFF, FN_SUB, "");
      // R5 R6
      drive32(32'hF0F0_F0F0, 32'hFF00_FF00, FN_AND, "");
      drive32(32'hFFFF_FFFF, 32'hFFFF_FFFF, FN_AND, "");
      drive32(32'hF0F0_F0F0, 32'h0F0F_0F0F, FN_OR, "");
      drive32(32'hFFFF_FFFF, 32'h0000_0001, FN_OR, "");
      // R7: same inputs again after different history
      drive32(32'hDEAD_BEEF, 32'h0BAD_F00D, FN_SUB, "R7");
      drive32(32'h1111_1111, 32'h2222_2222, FN_OR, "");
      drive32(32'hDEAD_BEEF, 32'h0BAD_F00D, FN_SUB, "R7");
      // pseudo-random operands for every function
      for (int i = 0; i < 300; i++) begin
         ra = $urandom;
         rb = $urandom;
         drive32(ra, rb, 2'(i % 4), "");
      end
      // R8 R9: exhaustive narrow sweep
      for (int f = 0; f < 4; f++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               drive4(4'(a), 4'(b), 2'(f));
      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         #1_000_000;
      join_any
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule